// File: doc/BRIEF.md
# Even-Lane Widening Multiplier

This datapath unit takes two 128-bit operand vectors, each viewed as four 32-bit lanes. It picks the even lanes (lanes 0 and 2) of both operands and multiplies them lane by lane as unsigned numbers. It then packs the two full-width 64-bit products into one 128-bit result. The odd lanes of both operands play no part.

Operands arrive with a valid strobe. The result leaves a fixed two clocks later with its own valid strobe. A new operand pair may be offered on every clock. The two lane products are formed side by side and do not depend on each other. The unit raises no flags and keeps no state beyond its pipeline.

Top module: `even_lane_wide_mul`

## Requirements
- R1: Result bits 63:0 hold the unsigned product of operand A bits 31:0 and operand B bits 31:0.
- R2: Result bits 127:64 hold the unsigned product of operand A bits 95:64 and operand B bits 95:64.
- R3: Each product is the full 64-bit value, with no truncation or saturation; 0xFFFFFFFF times 0xFFFFFFFF gives 0xFFFFFFFE00000001.
- R4: Bits 63:32 and 127:96 of either operand have no effect on the result.
- R5: out_valid is high exactly two clock edges after in_valid was sampled high, and the result belongs to that sampled pair; otherwise out_valid is low.
- R6: A new operand pair is accepted on every clock, so back-to-back inputs give back-to-back results in the same order.
- R7: A synchronous active-high rst clears every valid stage, so out_valid is low after any edge that samples rst high, including pairs already in flight.
- R8: The lanes are independent: a zero operand in one lane gives a zero product in that lane and leaves the other lane's product unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | 128 | Operand A, four 32-bit lanes |
| in_b | input | 128 | Operand B, four 32-bit lanes |
| out_valid | output | 1 | Result present this cycle |
| out_res | output | 128 | Two 64-bit products, lane 0 low, lane 2 high |

## Verification
Two functions meet in one cycle all the time. A fresh operand pair is captured in the same cycle that an earlier pair's result leaves. Reset can also land while pairs are still in the pipeline. The bench streams operands on every clock across a cross of edge-value patterns, with idle gaps mixed in, and checks each result against a shift-and-add model of the pair driven two cycles before. It also asserts reset with a valid pair on the input in the middle of a stream, and expects out_valid to stay low until fresh pairs have had two edges to pass through.

// File: rtl/evw_pkg.sv
package evw_pkg;
  // Number of register stages from operand capture to result
  localparam int PIPE_DEPTH = 2;

  // Lowest bit of a lane inside a packed vector
  function automatic int lane_base(input int lane, input int width);
    return lane * width;
  endfunction
endpackage

// File: rtl/evw_lane_pick.sv
module evw_lane_pick #(
  parameter int DW    = 32,
  parameter int LANES = 4
) (
  input  logic [DW*LANES-1:0]     vec,
  output logic [DW*(LANES/2)-1:0] even_lanes
);
  localparam int VEC_W = DW * LANES;
  localparam int PAIRS = LANES / 2;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pick
    // Shift the whole vector down and keep one lane; odd lanes fall away
    assign even_lanes[p*DW +: DW] =
      DW'(vec >> evw_pkg::lane_base(2 * p, DW));
  end
endmodule

// File: rtl/evw_lane_mul.sv
module evw_lane_mul #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic [2*DW-1:0] prod
);
  localparam int PW = 2 * DW;

  // Unsigned widening product: both factors zero-extended to full width
  function automatic logic [PW-1:0] widen_mul(input logic [DW-1:0] x,
                                              input logic [DW-1:0] y);
    logic [PW-1:0] xw;
    logic [PW-1:0] yw;
    xw = {{DW{1'b0}}, x};
    yw = {{DW{1'b0}}, y};
    return xw * yw;
  endfunction

  logic [DW-1:0] opa_q;
  logic [DW-1:0] opb_q;
  logic [PW-1:0] prod_q;

  // Stage one: capture operands
  always_ff @(posedge clk) begin
    opa_q <= opa;
    opb_q <= opb;
  end

  // Stage two: register the full product
  always_ff @(posedge clk) begin
    prod_q <= widen_mul(opa_q, opb_q);
  end

  assign prod = prod_q;
endmodule

// File: rtl/evw_valid_pipe.sv
module evw_valid_pipe #(
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_v,
  output logic [DEPTH-1:0] stage_v
);
  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic src;
    if (s == 0) begin : g_head
      assign src = in_v;
    end else begin : g_tail
      assign src = stage_v[s-1];
    end
    always_ff @(posedge clk) begin
      if (rst) stage_v[s] <= 1'b0;
      else     stage_v[s] <= src;
    end
  end
endmodule

// File: rtl/even_lane_wide_mul.sv
module even_lane_wide_mul #(
  parameter int DW    = 32,
  parameter int LANES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [DW*LANES-1:0] in_a,
  input  logic [DW*LANES-1:0] in_b,
  output logic                out_valid,
  output logic [DW*LANES-1:0] out_res
);
  localparam int VEC_W = DW * LANES;
  localparam int PAIRS = LANES / 2;
  localparam int PW    = 2 * DW;
  localparam int DEPTH = evw_pkg::PIPE_DEPTH;

  logic [DW*PAIRS-1:0] a_even;
  logic [DW*PAIRS-1:0] b_even;
  logic [DEPTH-1:0]    stage_v;

  // Named pipeline events, visible to the bound checker
  logic s1_valid;
  logic s2_valid;

  evw_lane_pick #(.DW(DW), .LANES(LANES)) u_pick_a (
    .vec        (in_a),
    .even_lanes (a_even)
  );

  evw_lane_pick #(.DW(DW), .LANES(LANES)) u_pick_b (
    .vec        (in_b),
    .even_lanes (b_even)
  );

  for (genvar p = 0; p < PAIRS; p++) begin : g_lane
    evw_lane_mul #(.DW(DW)) u_mul (
      .clk  (clk),
      .opa  (a_even[p*DW +: DW]),
      .opb  (b_even[p*DW +: DW]),
      .prod (out_res[p*PW +: PW])
    );
  end

  evw_valid_pipe #(.DEPTH(DEPTH)) u_vpipe (
    .clk     (clk),
    .rst     (rst),
    .in_v    (in_valid),
    .stage_v (stage_v)
  );

  assign s1_valid  = stage_v[0];
  assign s2_valid  = stage_v[DEPTH-1];
  assign out_valid = s2_valid;
endmodule

// File: rtl/even_lane_wide_mul_chk.sv
module even_lane_wide_mul_chk #(
  parameter int DW    = 32,
  parameter int LANES = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [DW*LANES-1:0] in_a,
  input logic [DW*LANES-1:0] in_b,
  input logic                s1_valid,
  input logic                out_valid,
  input logic [DW*LANES-1:0] out_res
);
  localparam int PW = 2 * DW;

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)           age <= 2'd0;
    else if (age != 3) age <= age + 2'd1;
  end

  logic [DW-1:0] a0, b0, a2, b2;
  assign a0 = DW'(in_a);
  assign b0 = DW'(in_b);
  assign a2 = DW'(in_a >> (2 * DW));
  assign b2 = DW'(in_b >> (2 * DW));

  logic [PW-1:0] lo_now, hi_now;
  assign lo_now = {{DW{1'b0}}, a0} * {{DW{1'b0}}, b0};
  assign hi_now = {{DW{1'b0}}, a2} * {{DW{1'b0}}, b2};

  // R1: low quadword from lane 0 products
  a_r1_low_product: assert property (@(posedge clk) disable iff (rst)
    (age >= 2 && out_valid) |-> out_res[PW-1:0] == $past(lo_now, 2));

  // R2: high quadword from lane 2 products
  a_r2_high_product: assert property (@(posedge clk) disable iff (rst)
    (age >= 2 && out_valid) |-> out_res[2*PW-1:PW] == $past(hi_now, 2));

  // R5: fixed two-edge latency of the valid strobe
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    (age >= 2) |-> out_valid == $past(in_valid, 2));

  // R6: first stage takes the strobe on every edge
  a_r6_every_cycle: assert property (@(posedge clk) disable iff (rst)
    (age >= 1) |-> s1_valid == $past(in_valid));

  // R7: nothing leaves right after reset
  a_r7_reset_clears: assert property (@(posedge clk) disable iff (rst)
    (age == 0) |-> (!out_valid && !s1_valid));
endmodule

bind even_lane_wide_mul even_lane_wide_mul_chk #(.DW(DW), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_a      (in_a),
  .in_b      (in_b),
  .s1_valid  (s1_valid),
  .out_valid (out_valid),
  .out_res   (out_res)
);

// File: tb/even_lane_wide_mul_test.sv
module even_lane_wide_mul_test;
  localparam int VW = 128;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [VW-1:0] in_a = '0;
  logic [VW-1:0] in_b = '0;
  logic          out_valid;
  logic [VW-1:0] out_res;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Expected entries for pairs driven one and two cycles back
  logic          p1_v, p2_v;
  logic [VW-1:0] p1_r, p2_r;
  string         p1_t, p2_t;

  even_lane_wide_mul uut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_res   (out_res)
  );

  // Shift-and-add unsigned product
  function automatic logic [63:0] shmul(input logic [31:0] x, input logic [31:0] y);
    logic [63:0] acc;
    logic [63:0] sh;
    acc = '0;
    sh  = {32'd0, x};
    for (int i = 0; i < 32; i++) begin
      if (y[i]) acc = acc + sh;
      sh = sh << 1;
    end
    return acc;
  endfunction

  function automatic logic [VW-1:0] model(input logic [VW-1:0] a, input logic [VW-1:0] b);
    return {shmul(a[95:64], b[95:64]), shmul(a[31:0], b[31:0])};
  endfunction

  function automatic logic [31:0] lcg(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  function automatic logic [31:0] pat(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h7FFF_FFFF;
      5: return 32'h0001_0000;
      6: return 32'hAAAA_5555;
      default: return 32'h1234_5678;
    endcase
  endfunction

  task automatic fail_line(input string req, input string what,
                           input logic [VW-1:0] act, input logic [VW-1:0] exp);
    errors++;
    $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
  endtask

  task automatic step(input bit r, input bit v, input logic [VW-1:0] a,
                      input logic [VW-1:0] b, input string tag);
    @(negedge clk);
    checks++;
    if (out_valid !== p2_v)
      fail_line(p2_t, "out_valid (R5)", VW'(out_valid), VW'(p2_v));
    if (p2_v) begin
      checks++;
      if (out_res[63:0] !== p2_r[63:0])
        fail_line(p2_t, "low product (R1)", VW'(out_res[63:0]), VW'(p2_r[63:0]));
      checks++;
      if (out_res[127:64] !== p2_r[127:64])
        fail_line(p2_t, "high product (R2)", VW'(out_res[127:64]), VW'(p2_r[127:64]));
    end
    if (r) begin
      // R7: reset wipes the pair still in flight and the one driven now
      p2_v = 1'b0; p2_t = tag;
      p1_v = 1'b0; p1_t = tag;
    end else begin
      p2_v = p1_v; p2_r = p1_r; p2_t = p1_t;
      p1_v = v;    p1_r = model(a, b); p1_t = tag;
    end
    rst      = r;
    in_valid = v;
    in_a     = a;
    in_b     = b;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    logic [VW-1:0] a, b;
    s = 32'h1ACE_2B07;
    p1_v = 1'b0; p2_v = 1'b0; p1_r = '0; p2_r = '0;
    p1_t = "R7"; p2_t = "R7";
    repeat (2) @(negedge clk);

    // R7: reset state, out_valid low while reset held
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0, '0, '0, "R7");

    // R1 R2 R6: back-to-back cross of edge patterns, odd lanes random (R4)
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [31:0] o0, o1, o2, o3;
        s = lcg(s); o0 = s; s = lcg(s); o1 = s; s = lcg(s); o2 = s; s = lcg(s); o3 = s;
        a = {o0, pat(7 - j), o1, pat(i)};
        b = {o2, pat(i ^ 3), o3, pat(j)};
        step(1'b0, 1'b1, a, b, "R1 R2 R6");
        if (((i * 8 + j) % 9) == 8) step(1'b0, 1'b0, '0, '0, "R5");
      end
    end

    // R3: largest operands in both lanes
    step(1'b0, 1'b1, {32'h0, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF},
                     {32'h0, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF}, "R3");
    step(1'b0, 1'b0, '0, '0, "R5");

    // R8: zero in one lane only, other lane carries a large product
    step(1'b0, 1'b1, {32'h5, 32'hDEAD_BEEF, 32'h9, 32'h0},
                     {32'h6, 32'hFFFF_FFFF, 32'h7, 32'hCAFE_F00D}, "R8");
    step(1'b0, 1'b1, {32'h5, 32'h0, 32'h9, 32'hFFFF_FFFF},
                     {32'h6, 32'h1234_5678, 32'h7, 32'hFFFF_FFFE}, "R8");

    // R4: fixed even lanes, odd lanes varied, result must not move
    for (int k = 0; k < 6; k++) begin
      logic [31:0] o0, o1, o2, o3;
      s = lcg(s); o0 = s; s = lcg(s); o1 = s; s = lcg(s); o2 = s; s = lcg(s); o3 = s;
      step(1'b0, 1'b1, {o0, 32'h89AB_CDEF, o1, 32'h0F0F_F0F0},
                       {o2, 32'h7654_3210, o3, 32'hFEDC_BA98}, "R4");
    end

    // R7: reset arrives mid-stream with a valid pair on the input
    step(1'b0, 1'b1, {4{32'h1111_2222}}, {4{32'h3333_4444}}, "R6");
    step(1'b1, 1'b1, {4{32'h5555_6666}}, {4{32'h7777_8888}}, "R7");
    step(1'b0, 1'b1, {4{32'h9999_AAAA}}, {4{32'hBBBB_CCCC}}, "R7 R5");
    step(1'b0, 1'b1, {4{32'hDDDD_EEEE}}, {4{32'h0000_FFFF}}, "R6");

    // R1 R2: random stream with occasional gaps
    for (int k = 0; k < 150; k++) begin
      s = lcg(s); a[31:0] = s;  s = lcg(s); a[63:32] = s;
      s = lcg(s); a[95:64] = s; s = lcg(s); a[127:96] = s;
      s = lcg(s); b[31:0] = s;  s = lcg(s); b[63:32] = s;
      s = lcg(s); b[95:64] = s; s = lcg(s); b[127:96] = s;
      step(1'b0, (k % 11) != 5, a, b, "R1 R2");
    end

    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, '0, '0, "R5");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule